// File: doc/BRIEF.md
# Lane Reduce-and-Scan Engine

This block combines a tile of signed 32-bit lane values using a logarithmic tree of lane-to-lane exchanges. It takes one exchange step per clock and holds no memory besides the lane register file. A single start pulse latches the lane vector, an operation code and a per-lane active mask. The engine then computes one of four things. Three are reductions: sum, signed maximum and signed minimum. The fourth is an inclusive prefix sum across the lanes.

The reductions use halving downward exchanges. Each lane combines its own value with the value held a fixed distance above it, and the distance halves on every step. After the last step lane 0 holds the total, and one more cycle copies it to every lane. The prefix sum uses doubling upward exchanges, in which only lanes at or above the current distance add the value fetched from below. The tile width is a parameter (4, 8, 16 or 32 lanes). It sets the number of steps to log2 of the width. A one-cycle done pulse marks the cycle in which the result vector is valid. The result then stays unchanged until the next accepted start.

Top module: `lane_fold_engine`

## Requirements
- R1: While reset is applied and in the first cycle after it, `done_o` is 0 and every lane of `result_o` is 0.
- R2: With `op_i` = 0 (sum), every lane of the result equals the sum of the active input lanes.
- R3: With `op_i` = 1 (max), every lane of the result equals the largest active input lane, compared as signed two's-complement values.
- R4: With `op_i` = 2 (min), every lane of the result equals the smallest active input lane, compared as signed values.
- R5: With `op_i` = 3 (scan), result lane i equals the sum of the active input lanes 0 through i.
- R6: A lane whose bit in `mask_i` is 0 contributes the identity of the operation: 0 for sum and scan, 0x80000000 for max, 0x7FFFFFFF for min.
- R7: Sum and scan wrap modulo 2^32 and never saturate.
- R8: A start is accepted at the clock edge where `start_i` is 1 and the engine is idle. For scan, `done_o` is high in the cycle after the log2(LANES)-th edge that follows the accepting edge. For the reductions it is high in the cycle after the (log2(LANES)+1)-th edge.
- R9: `done_o` stays high for exactly one cycle for each accepted start.
- R10: A start pulse that arrives while an operation is in progress is ignored. It changes neither the result, nor the done timing, nor the number of done pulses.
- R11: Once `done_o` has been high, `result_o` holds its value until the next accepted start.
- R12: After a reduction, all lanes of `result_o` hold the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, sampled when the engine is idle |
| op_i | input | 2 | Operation: 0 sum, 1 max, 2 min, 3 inclusive scan |
| lanes_i | input | LANES*32 | Input lane values, lane i at bits [32*i +: 32] |
| mask_i | input | LANES | Active mask, bit i set for an active lane |
| result_o | output | LANES*32 | Result lane values, same packing as the input |
| done_o | output | 1 | One-cycle pulse when the result is valid |

## Verification
On every cycle the checker asserts four properties. The done pulse must arrive exactly at the step count for the latched operation, and it must last one cycle. The lanes must be equal after a reduction, and the result must not change while the engine stays idle. The bench is the only place where arithmetic correctness shows. It sweeps all 256 masks of an 8-lane tile for each operation against a sequential reference, covering identity injection, signed ordering and modulo wrap on extreme patterns. It also shows, through timing and the count of done pulses, that a start arriving mid-operation is ignored.

// File: rtl/lane_fold_pkg.sv
package lane_fold_pkg;

    typedef enum logic [1:0] {
        FOLD_SUM  = 2'd0,
        FOLD_MAX  = 2'd1,
        FOLD_MIN  = 2'd2,
        FOLD_SCAN = 2'd3
    } fold_op_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_STEP  = 2'd1,
        PH_BCAST = 2'd2
    } phase_e;

endpackage

// File: rtl/lane_fold_seed.sv
// Replaces inactive lanes with the identity element of the selected operation.
module lane_fold_seed
    import lane_fold_pkg::*;
#(
    parameter int LANES = 32,
    parameter int DW    = 32
) (
    input  fold_op_e               op_i,
    input  logic [LANES*DW-1:0]    lanes_i,
    input  logic [LANES-1:0]       mask_i,
    output logic [LANES*DW-1:0]    seed_o
);

    logic [DW-1:0] ident;

    always_comb begin
        case (op_i)
            FOLD_MAX: ident = {1'b1, {(DW-1){1'b0}}};
            FOLD_MIN: ident = {1'b0, {(DW-1){1'b1}}};
            default:  ident = '0;
        endcase
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign seed_o[g*DW +: DW] = mask_i[g] ? lanes_i[g*DW +: DW] : ident;
    end

endmodule

// File: rtl/lane_fold_stage.sv
// One exchange step: every lane fetches a partner at a run-time distance.
module lane_fold_stage
    import lane_fold_pkg::*;
#(
    parameter int LANES = 32,
    parameter int DW    = 32,
    localparam int OW   = $clog2(LANES),
    localparam int LW   = $clog2(LANES)
) (
    input  fold_op_e               op_i,
    input  logic [OW-1:0]          offset_i,
    input  logic [LANES*DW-1:0]    vals_i,
    output logic [LANES*DW-1:0]    vals_o
);

    logic [DW-1:0] v [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_unpack
        assign v[g] = vals_i[g*DW +: DW];
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        int            src;
        logic          take;
        logic [DW-1:0] own;
        logic [DW-1:0] nb;
        logic [DW-1:0] res;

        always_comb begin
            own = v[g];
            if (op_i == FOLD_SCAN) begin
                src  = g - int'(offset_i);
                take = (src >= 0);
            end else begin
                src  = g + int'(offset_i);
                take = (src < LANES);
            end
            nb = v[LW'(src)];
            case (op_i)
                FOLD_MAX: res = (take && ($signed(nb) > $signed(own))) ? nb : own;
                FOLD_MIN: res = (take && ($signed(nb) < $signed(own))) ? nb : own;
                default:  res = take ? (own + nb) : own;
            endcase
        end

        assign vals_o[g*DW +: DW] = res;
    end

endmodule

// File: rtl/lane_fold_engine.sv
module lane_fold_engine
    import lane_fold_pkg::*;
#(
    parameter int LANES = 32,
    parameter int DW    = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic [1:0]             op_i,
    input  logic [LANES*DW-1:0]    lanes_i,
    input  logic [LANES-1:0]       mask_i,
    output logic [LANES*DW-1:0]    result_o,
    output logic                   done_o
);

    localparam int STEPS = $clog2(LANES);
    localparam int CW    = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam int OW    = $clog2(LANES);
    localparam int VW    = LANES * DW;

    typedef struct packed {
        phase_e        phase;
        logic [CW-1:0] cnt;
        fold_op_e      op;
        logic [VW-1:0] vals;
        logic          done;
    } eng_t;

    eng_t          st_d, st_q;
    fold_op_e      op_in;
    logic [VW-1:0] seed;
    logic [VW-1:0] stepped;
    logic [OW-1:0] offset;
    logic          eng_idle;

    assign op_in = fold_op_e'(op_i);

    lane_fold_seed #(.LANES(LANES), .DW(DW)) seed_i (
        .op_i    (op_in),
        .lanes_i (lanes_i),
        .mask_i  (mask_i),
        .seed_o  (seed)
    );

    lane_fold_stage #(.LANES(LANES), .DW(DW)) stage_i (
        .op_i     (st_q.op),
        .offset_i (offset),
        .vals_i   (st_q.vals),
        .vals_o   (stepped)
    );

    // Scan distances double from 1; reduction distances halve from LANES/2.
    always_comb begin
        if (st_q.op == FOLD_SCAN) begin
            offset = OW'(1 << st_q.cnt);
        end else begin
            offset = OW'(LANES >> (int'(st_q.cnt) + 1));
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.phase)
            PH_STEP: begin
                st_d.vals = stepped;
                if (st_q.cnt == CW'(STEPS - 1)) begin
                    if (st_q.op == FOLD_SCAN) begin
                        st_d.phase = PH_IDLE;
                        st_d.done  = 1'b1;
                    end else begin
                        st_d.phase = PH_BCAST;
                    end
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            PH_BCAST: begin
                for (int i = 0; i < LANES; i++) begin
                    st_d.vals[i*DW +: DW] = st_q.vals[DW-1:0];
                end
                st_d.phase = PH_IDLE;
                st_d.done  = 1'b1;
            end
            default: begin
                if (start_i) begin
                    st_d.phase = PH_STEP;
                    st_d.cnt   = '0;
                    st_d.op    = op_in;
                    st_d.vals  = seed;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, cnt: '0, op: FOLD_SUM, vals: '0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign eng_idle = (st_q.phase == PH_IDLE);
    assign result_o = st_q.vals;
    assign done_o   = st_q.done;

endmodule

// File: rtl/lane_fold_checker.sv
module lane_fold_checker #(
    parameter int LANES = 32,
    parameter int DW    = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start_i,
    input logic [1:0]             op_i,
    input logic                   idle_i,
    input logic [LANES*DW-1:0]    result_o,
    input logic                   done_o
);

    localparam int STEPS = $clog2(LANES);

    logic [3:0] lat_q;
    logic [1:0] op_l;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q <= '0;
            op_l  <= '0;
        end else if (start_i && idle_i) begin
            lat_q <= '0;
            op_l  <= op_i;
        end else if (!idle_i) begin
            lat_q <= lat_q + 4'd1;
        end
    end

    // R8: done arrives after exactly the step count of the latched operation
    p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (int'(lat_q) == ((op_l == 2'd3) ? STEPS : STEPS + 1)));

    // R8: done only once the engine is back to idle
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> idle_i);

    // R9: done lasts one cycle
    p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R12: reductions leave every lane equal
    p_bcast_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (op_l != 2'd3)) |-> (result_o == {LANES{result_o[DW-1:0]}}));

    // R11: result frozen while idle
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_i && $past(idle_i)) |-> $stable(result_o));

endmodule

bind lane_fold_engine lane_fold_checker #(.LANES(LANES), .DW(DW)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .op_i     (op_i),
    .idle_i   (eng_idle),
    .result_o (result_o),
    .done_o   (done_o)
);

// File: tb/lane_fold_engine_tb_top.sv
`timescale 1ns/1ps
module lane_fold_engine_tb_top;

    localparam int N  = 8;
    localparam int DW = 32;
    localparam int S  = 3;

    logic            clk   = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [1:0]      op    = 2'd0;
    logic [N*DW-1:0] lanes = '0;
    logic [N-1:0]    mask  = '0;
    logic [N*DW-1:0] res;
    logic            done;

    int          checks   = 0;
    int          fails    = 0;
    bit          finished = 1'b0;
    logic [31:0] rng      = 32'h1234_5678;

    always #2.5 clk = ~clk;

    lane_fold_engine #(.LANES(N), .DW(DW)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .op_i     (op),
        .lanes_i  (lanes),
        .mask_i   (mask),
        .result_o (res),
        .done_o   (done)
    );

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        logic [31:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    // Sequential reference: left-to-right accumulation, not a tree.
    function automatic logic [N*DW-1:0] model(input logic [1:0] o,
                                             input logic [N*DW-1:0] v,
                                             input logic [N-1:0] m);
        logic signed [31:0] x [N];
        logic signed [31:0] acc;
        logic [N*DW-1:0]    r;
        for (int i = 0; i < N; i++) begin
            if (m[i])           x[i] = v[i*DW +: DW];
            else if (o == 2'd1) x[i] = 32'sh8000_0000;
            else if (o == 2'd2) x[i] = 32'sh7FFF_FFFF;
            else                x[i] = 32'sd0;
        end
        if (o == 2'd3) begin
            acc = 0;
            for (int i = 0; i < N; i++) begin
                acc = acc + x[i];
                r[i*DW +: DW] = acc;
            end
        end else begin
            acc = x[0];
            for (int i = 1; i < N; i++) begin
                if (o == 2'd0)      acc = acc + x[i];
                else if (o == 2'd1) acc = (x[i] > acc) ? x[i] : acc;
                else                acc = (x[i] < acc) ? x[i] : acc;
            end
            for (int i = 0; i < N; i++) r[i*DW +: DW] = acc;
        end
        return r;
    endfunction

    function automatic string op_tag(input logic [1:0] o);
        case (o)
            2'd0:    return "R2/R12 sum";
            2'd1:    return "R3/R12 max";
            2'd2:    return "R4/R12 min";
            default: return "R5 scan";
        endcase
    endfunction

    task automatic check_vec(input string tag, input logic [N*DW-1:0] got,
                             input logic [N*DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic check_int(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic run_vec(input logic [1:0] o, input logic [N*DW-1:0] v,
                           input logic [N-1:0] m, input bit poke, input string extra);
        logic [N*DW-1:0] exp;
        int              n;
        int              want;
        int              hold;
        bit              bad;
        string           tag;
        exp  = model(o, v, m);
        want = (o == 2'd3) ? S + 1 : S + 2;
        tag  = {op_tag(o), (m != '1) ? " R6" : "", extra};
        @(negedge clk);
        start = 1'b1; op = o; lanes = v; mask = m;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!done && n < 40) begin
            @(negedge clk);
            n++;
            if (poke && n == 2) begin
                start = 1'b1; op = o ^ 2'b01; lanes = ~v; mask = ~m;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        check_int({tag, " R8 latency"}, n, want);
        check_vec(tag, res, exp);
        @(negedge clk);
        check_int("R9 done pulse width", int'(done), 0);
        hold = poke ? 8 : 2;
        bad  = 1'b0;
        for (int k = 0; k < hold; k++) begin
            if (done || res !== exp) bad = 1'b1;
            @(negedge clk);
        end
        check_int(poke ? "R10 busy start ignored" : "R11 result hold", int'(bad), 0);
    endtask

    initial begin : main
        logic [N*DW-1:0] v;
        repeat (3) @(negedge clk);
        check_int("R1 reset done", int'(done), 0);
        check_vec("R1 reset result", res, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check_int("R1 post-reset done", int'(done), 0);
        check_vec("R1 post-reset result", res, '0);

        for (int o = 0; o < 4; o++) begin
            for (int m = 0; m < 256; m++) begin
                for (int i = 0; i < N; i++) begin
                    rng = next_rand(rng);
                    v[i*DW +: DW] = (m[0]) ? rng : {{28{rng[31]}}, rng[3:0]};
                end
                run_vec(2'(o), v, 8'(m), 1'b0, "");
            end
        end

        v = {N{32'h7FFF_FFFF}};
        run_vec(2'd0, v, '1, 1'b0, " R7 wrap");
        run_vec(2'd3, v, '1, 1'b0, " R7 wrap");
        v = {N{32'h8000_0000}};
        run_vec(2'd0, v, '1, 1'b0, " R7 wrap");
        run_vec(2'd1, v, '1, 1'b0, " extreme");
        run_vec(2'd2, v, '1, 1'b0, " extreme");
        v = {N{32'h7FFF_FFFF}};
        run_vec(2'd1, v, '1, 1'b0, " extreme");
        run_vec(2'd2, v, '1, 1'b0, " extreme");
        run_vec(2'd1, v, '0, 1'b0, " all inactive");
        run_vec(2'd2, v, '0, 1'b0, " all inactive");

        for (int o = 0; o < 4; o++) begin
            for (int r = 0; r < 3; r++) begin
                for (int i = 0; i < N; i++) begin
                    rng = next_rand(rng);
                    v[i*DW +: DW] = rng;
                end
                rng = next_rand(rng);
                run_vec(2'(o), v, rng[7:0], 1'b1, " R10");
            end
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule